// File: doc/BRIEF.md
# Tagged integer arithmetic unit

This block is a 64-bit execution unit for dynamically typed integers. Every operand word carries a one-bit tag in its least significant position. The tag says whether the word holds a small signed integer inline or a reference to an arbitrary-precision value kept in heap storage. In one registered step the unit takes two operand words, an operation code and a mode bit. It inspects both tags, performs addition, subtraction or multiplication on the integer payloads, and checks whether the exact answer fits back into the inline form.

On the fast path the unit delivers a correctly tagged result one clock after issue. When an operand is a reference, or when the result overflows, the unit suppresses the result. Instead it raises a trap carrying a handler address. That address is read from a small table which software fills in advance through a write port. The table is indexed by the mode bit together with a cause code.

The mode bit does not change the datapath. It only selects which half of the table supplies the handler. Software can therefore use one half to promote values to arbitrary precision and the other half to report overflow as an error.

Top module: `tagint_alu`

## Requirements
- R1: Word bit 0 equal to 1 marks an inline integer whose value is the word arithmetically shifted right by one; bit 0 equal to 0 marks a reference. Every delivered result has bit 0 set.
- R2: With `in_op` = 0 (add) and both tags set, the clock edge that samples `in_valid` produces `res_valid` = 1 and `res_data` = tagged (x + y), when the sum fits in 63 signed bits.
- R3: With `in_op` = 1 (subtract) and both tags set, the result is tagged (x − y) under the same timing, when it fits in 63 signed bits.
- R4: When `in_op[1]` = 1 (codes 2 and 3), the unit multiplies, and the result is tagged (x · y) when the product fits in 63 signed bits.
- R5: An add or subtract whose exact result lies outside [−2^62, 2^62 − 1] raises a trap with cause 2 (overflow) instead of a result.
- R6: A product outside [−2^62, 2^62 − 1] raises a trap with cause 2. A product of exactly −2^62 is delivered as a result.
- R7: A left operand with bit 0 = 0 raises a trap with cause 0, whatever the right operand holds and whatever the arithmetic outcome would be.
- R8: A right operand with bit 0 = 0 and a tagged-integer left operand raises a trap with cause 1, which wins over overflow.
- R9: The trap target is table entry {`in_mode`, cause}: entries 0–2 for mode 0 and entries 4–6 for mode 1. Results are the same in both modes.
- R10: A write with `tbl_we` = 1 stores `tbl_wdata` in entry `tbl_addr`. A trap issued on any later cycle reads the new value. The table is not cleared by reset.
- R11: `res_valid` and `trap_valid` are never high together. A cycle with `in_valid` = 0 yields neither of them on the next cycle, with `res_data` and `trap_target` both zero.
- R12: While `rst` is high, on the following edge all outputs are zero.
- R13: During a trap `res_data` is zero. During a result `trap_target` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue an operation this cycle |
| in_op | input | 2 | 0 add, 1 subtract, 2 or 3 multiply |
| in_mode | input | 1 | Handler-table half select |
| in_a | input | XLEN | Left tagged operand |
| in_b | input | XLEN | Right tagged operand |
| tbl_we | input | 1 | Handler table write enable |
| tbl_addr | input | 3 | Handler table entry to write |
| tbl_wdata | input | XLEN | Handler address to store |
| res_valid | output | 1 | Tagged result delivered |
| res_data | output | XLEN | Tagged result word |
| trap_valid | output | 1 | Exceptional case, handler redirect |
| trap_target | output | XLEN | Handler address from the table |

## Verification
Each operation is driven with small mixed-sign integers, which confirms that the tag bit is kept. Each is also driven with values exactly at the 63-bit limits and one step beyond, which separates a correct overflow threshold from an off-by-one. Reference operands are placed on the left, on the right, on both sides, and on the right together with an overflowing payload. These cases separate the three cause priorities. Every trap case is repeated in both modes, and one table entry is rewritten between traps, so that a wrong index bit or a stale read shows up as the wrong handler address.

// File: rtl/tagint_pkg.sv
package tagint_pkg;
  localparam int CAUSEW = 2;
  localparam int IDXW   = CAUSEW + 1;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_MUL  = 2'd2,
    OP_MUL2 = 2'd3
  } op_e;

  typedef enum logic [CAUSEW-1:0] {
    CAUSE_LPTR = 2'd0,
    CAUSE_RPTR = 2'd1,
    CAUSE_OVF  = 2'd2,
    CAUSE_NONE = 2'd3
  } cause_e;
endpackage

// File: rtl/tagint_addsub.sv
module tagint_addsub #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  output logic [XLEN-1:0] sum,
  output logic            ovf
);
  localparam int EW = XLEN + 2;

  logic signed [EW-1:0] ax, bx, kx, s;

  always_comb begin
    ax  = {{2{a[XLEN-1]}}, a};
    bx  = sub ? ~{{2{b[XLEN-1]}}, b} : {{2{b[XLEN-1]}}, b};
    // tagged add: a + b - 1 ; tagged subtract: a + ~b + 2 = a - b + 1
    kx  = sub ? EW'(2) : {EW{1'b1}};
    s   = ax + bx + kx;
    sum = s[XLEN-1:0];
    ovf = !((s[EW-1] == s[EW-2]) && (s[EW-2] == s[XLEN-1]));
  end
endmodule

// File: rtl/tagint_mul.sv
module tagint_mul #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] prod,
  output logic            ovf
);
  localparam int PW = XLEN - 1;
  localparam int FW = 2 * PW;

  logic signed [FW-1:0] xe, ye, p;
  logic [FW-PW:0]       hi;

  always_comb begin
    xe   = {{PW{a[XLEN-1]}}, a[XLEN-1:1]};
    ye   = {{PW{b[XLEN-1]}}, b[XLEN-1:1]};
    p    = xe * ye;
    hi   = p[FW-1:PW-1];
    ovf  = !((&hi) || !(|hi));
    prod = {p[PW-1:0], 1'b1};
  end
endmodule

// File: rtl/tagint_classify.sv
module tagint_classify
  import tagint_pkg::*;
(
  input  logic            a_int,
  input  logic            b_int,
  input  logic            ovf,
  input  logic            mode,
  output logic            trap,
  output logic [IDXW-1:0] idx
);
  cause_e cause;

  always_comb begin
    if (!a_int)      cause = CAUSE_LPTR;
    else if (!b_int) cause = CAUSE_RPTR;
    else if (ovf)    cause = CAUSE_OVF;
    else             cause = CAUSE_NONE;
    trap = (cause != CAUSE_NONE);
    idx  = {mode, cause};
  end

  always_comb begin
    if (!a_int) a_lptr_r7 : assert (idx[CAUSEW-1:0] == 2'd0);
    if (a_int && !b_int) a_rptr_r8 : assert (idx[CAUSEW-1:0] == 2'd1);
  end
endmodule

// File: rtl/tagint_vector_table.sv
module tagint_vector_table #(
  parameter int DW = 64,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tagint_alu.sv
module tagint_alu
  import tagint_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic            in_mode,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic            tbl_we,
  input  logic [IDXW-1:0] tbl_addr,
  input  logic [XLEN-1:0] tbl_wdata,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data,
  output logic            trap_valid,
  output logic [XLEN-1:0] trap_target
);
  logic [XLEN-1:0] as_sum, mul_prod, arith;
  logic            as_ovf, mul_ovf, ovf, trap;
  logic [IDXW-1:0] idx;
  logic [XLEN-1:0] tbl_q;
  logic            is_mul;

  assign is_mul = in_op[1];

  tagint_addsub #(.XLEN(XLEN)) u_addsub (
    .a(in_a), .b(in_b), .sub(in_op == OP_SUB), .sum(as_sum), .ovf(as_ovf)
  );

  tagint_mul #(.XLEN(XLEN)) u_mul (
    .a(in_a), .b(in_b), .prod(mul_prod), .ovf(mul_ovf)
  );

  assign arith = is_mul ? mul_prod : as_sum;
  assign ovf   = is_mul ? mul_ovf  : as_ovf;

  tagint_classify u_cls (
    .a_int(in_a[0]), .b_int(in_b[0]), .ovf(ovf), .mode(in_mode),
    .trap(trap), .idx(idx)
  );

  tagint_vector_table #(.DW(XLEN), .AW(IDXW)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .re(in_valid && trap), .raddr(idx), .rdata(tbl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      trap_valid <= 1'b0;
      res_data   <= '0;
    end else begin
      res_valid  <= in_valid && !trap;
      trap_valid <= in_valid && trap;
      res_data   <= (in_valid && !trap) ? arith : '0;
    end
  end

  assign trap_target = trap_valid ? tbl_q : '0;

  p_exclusive_r11 : assert property (@(posedge clk) disable iff (rst)
    !(res_valid && trap_valid));
  p_idle_r11 : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && !trap_valid));
  p_tag_r1 : assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_data[0]);
  p_lptr_r7 : assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_a[0]) |=> trap_valid);
  p_no_overflow_r5 : assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_a[0] && in_b[0] && !is_mul && as_ovf) |=> trap_valid);
  p_mul_ovf_r6 : assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_a[0] && in_b[0] && is_mul && mul_ovf) |=> trap_valid);
  p_quiet_data_r13 : assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> (res_data == '0));
endmodule

// File: tb/test_tagint_alu.sv
module test_tagint_alu;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [1:0]      in_op = '0;
  logic            in_mode = 1'b0;
  logic [XLEN-1:0] in_a = '0, in_b = '0;
  logic            tbl_we = 1'b0;
  logic [2:0]      tbl_addr = '0;
  logic [XLEN-1:0] tbl_wdata = '0;
  logic            res_valid, trap_valid;
  logic [XLEN-1:0] res_data, trap_target;

  int n_cmp = 0;
  int n_bad = 0;
  logic [XLEN-1:0] handler [8];

  always #10 clk = ~clk;

  tagint_alu #(.XLEN(XLEN)) i_tagint_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_mode(in_mode),
    .in_a(in_a), .in_b(in_b), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .res_valid(res_valid), .res_data(res_data),
    .trap_valid(trap_valid), .trap_target(trap_target)
  );

  localparam logic signed [127:0] HI = (128'sd1 <<< 62) - 128'sd1;
  localparam logic signed [127:0] LO = -(128'sd1 <<< 62);

  function automatic logic [XLEN-1:0] tg(input logic signed [127:0] v);
    return {v[62:0], 1'b1};
  endfunction

  function automatic logic [XLEN-1:0] ptr(input logic [XLEN-1:0] addr);
    return {addr[XLEN-1:1], 1'b0};
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic write_tbl(input int i, input logic [XLEN-1:0] v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 3'(i); tbl_wdata = v;
    @(negedge clk);
    tbl_we = 1'b0;
    handler[i] = v;
  endtask

  // Issues one operation, computes the expected outcome, and checks all outputs.
  task automatic run(input string req, input logic [1:0] op, input logic mode,
                     input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    logic signed [127:0] x, y, r;
    logic exp_trap;
    logic [1:0] cause;
    logic [XLEN-1:0] exp_res, exp_tgt;
    x = $signed(a) >>> 1;
    y = $signed(b) >>> 1;
    case (op)
      2'd0:    r = x + y;
      2'd1:    r = x - y;
      default: r = x * y;
    endcase
    exp_trap = 1'b1;
    if (!a[0])                 cause = 2'd0;
    else if (!b[0])            cause = 2'd1;
    else if (r > HI || r < LO) cause = 2'd2;
    else begin cause = 2'd3; exp_trap = 1'b0; end
    exp_res = exp_trap ? '0 : tg(r);
    exp_tgt = exp_trap ? handler[{mode, cause}] : '0;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_mode = mode; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    cmp(req, "res_valid", 64'(res_valid), 64'(!exp_trap));
    cmp(req, "trap_valid", 64'(trap_valid), 64'(exp_trap));
    cmp(req, "res_data", res_data, exp_res);
    cmp(req, "trap_target", trap_target, exp_tgt);
  endtask

  task automatic t_reset;
    // R12: outputs zero after reset edge
    cmp("R12", "res_valid", 64'(res_valid), 64'd0);
    cmp("R12", "trap_valid", 64'(trap_valid), 64'd0);
    cmp("R12", "res_data", res_data, 64'd0);
    cmp("R12", "trap_target", trap_target, 64'd0);
  endtask

  task automatic t_add;
    run("R2", 2'd0, 1'b0, tg(5), tg(7));
    run("R2", 2'd0, 1'b1, tg(-100), tg(37));
    run("R1", 2'd0, 1'b0, tg(-1), tg(-1));
    run("R2", 2'd0, 1'b0, tg(HI), tg(0));
  endtask

  task automatic t_sub;
    run("R3", 2'd1, 1'b0, tg(3), tg(10));
    run("R3", 2'd1, 1'b1, tg(-50), tg(-50));
    run("R3", 2'd1, 1'b0, tg(LO + 1), tg(1));
  endtask

  task automatic t_mul;
    run("R4", 2'd2, 1'b0, tg(-12), tg(11));
    run("R4", 2'd3, 1'b0, tg(123456), tg(-789));
    run("R6", 2'd2, 1'b0, tg(-(128'sd1 <<< 31)), tg(128'sd1 <<< 31));
  endtask

  task automatic t_overflow;
    run("R5", 2'd0, 1'b0, tg(HI), tg(1));
    run("R5", 2'd1, 1'b1, tg(LO), tg(1));
    run("R5", 2'd0, 1'b1, tg(LO), tg(-1));
    run("R6", 2'd2, 1'b0, tg(128'sd1 <<< 31), tg(128'sd1 <<< 31));
    run("R6", 2'd3, 1'b1, tg(HI), tg(-2));
  endtask

  task automatic t_pointers;
    run("R7", 2'd0, 1'b0, ptr(64'h0000_1000), tg(1));
    run("R7", 2'd2, 1'b1, ptr(64'h0000_2000), ptr(64'h0000_3000));
    run("R8", 2'd0, 1'b0, tg(HI), ptr(64'h0000_4000));
    run("R8", 2'd1, 1'b1, tg(7), ptr(64'h0000_5000));
  endtask

  task automatic t_modes;
    // R9: same operands, each mode, expect distinct table halves
    run("R9", 2'd0, 1'b0, tg(HI), tg(HI));
    run("R9", 2'd0, 1'b1, tg(HI), tg(HI));
    run("R9", 2'd2, 1'b1, tg(9), tg(-9));
  endtask

  task automatic t_rewrite;
    // R10: new entry visible to a later trap
    write_tbl(2, 64'hFEED_0000_0000_0AB0);
    run("R10", 2'd0, 1'b0, tg(HI), tg(HI));
    write_tbl(4, 64'hBEEF_0000_0000_0CC0);
    run("R10", 2'd1, 1'b1, ptr(64'h40), tg(0));
  endtask

  task automatic t_idle;
    // R11: no issue means no output on the next cycle
    @(negedge clk);
    in_valid = 1'b0; in_a = ptr(64'h80); in_b = tg(HI); in_op = 2'd0;
    @(negedge clk);
    cmp("R11", "res_valid", 64'(res_valid), 64'd0);
    cmp("R11", "trap_valid", 64'(trap_valid), 64'd0);
    cmp("R11", "trap_target", trap_target, 64'd0);
    cmp("R13", "res_data", res_data, 64'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    for (int i = 0; i < 8; i++) write_tbl(i, 64'h1000_0000_0000_0000 + 64'(i) * 64'h40);
    t_add();
    t_sub();
    t_mul();
    t_overflow();
    t_pointers();
    t_modes();
    t_rewrite();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule